// File: doc/BRIEF.md
# IDE PIO strobe timing generator

This block shapes one programmed-I/O access on a two-channel IDE host port. A single start pulse, together with the direction, the channel, the drive on that channel and a flag for command-block accesses, launches a cycle of three back-to-back phases: address setup, the active phase in which the read or write strobe is driven, and recovery. Each phase lasts a number of bus clocks taken from encoded timing fields that the surrounding configuration logic supplies. The block holds address-valid high for the whole cycle and marks the last recovery clock with a done pulse.

The two drives on the primary channel have separate timing fields. The two secondary drives share one set. Command-block accesses take their active and recovery counts from a separate timing byte. One start request that arrives while a cycle is under way is held and begins on the clock after the done pulse, so the bus sees no idle gap between the two cycles.

Top module: `pio_strobe_gen`

## Requirements
- R1: The setup phase drives address-valid with both strobes low. Its length comes from the selected 2-bit setup code: 00 gives 4 clocks, 01 gives 2, 10 gives 3 and 11 gives 5.
- R2: The active phase follows setup. It lasts the upper nibble of the selected timing byte in clocks, where 0 means 16 and 1 is stretched to 2. Only the read strobe is high when wr_i was 0 at the request, and only the write strobe when it was 1.
- R3: The recovery phase follows the active phase with both strobes low. It lasts the lower nibble of the selected timing byte in clocks, where 0 means 16, plus one extra clock when rev_i is greater than 1.
- R4: done_o is high for exactly one clock, the last recovery clock. Address-valid falls on the next clock unless a request is held.
- R5: On channel 0 (chan_i=0), drive 0 uses su_pri0_i/rw_pri0_i and drive 1 uses su_pri1_i/rw_pri1_i. On channel 1, both drives use su_sec_i/rw_sec_i.
- R6: With cmd_blk_i=1, the active and recovery counts come from rw_cmd_i (same nibble layout, so 0x00 gives the slowest 16/16). The setup code is still the one selected by R5.
- R7: A start that arrives while a cycle is in progress, including in its done cycle, begins its setup phase on the clock right after done_o. The request keeps the direction, channel, drive and flag it had when it arrived, and address-valid stays high across the join.
- R8: During and after reset, with no start given, all outputs are low.
- R9: The read and write strobes are never high together, and a strobe is never high without address-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse for one access |
| wr_i | input | 1 | 1 = write access, 0 = read access |
| chan_i | input | 1 | Channel select (0 primary, 1 secondary) |
| drv_i | input | 1 | Drive select on the channel |
| cmd_blk_i | input | 1 | Access targets the command register block |
| rev_i | input | 2 | Silicon revision code |
| su_pri0_i | input | 2 | Setup code, primary drive 0 |
| su_pri1_i | input | 2 | Setup code, primary drive 1 |
| su_sec_i | input | 2 | Setup code, shared by secondary drives |
| rw_pri0_i | input | 8 | Active/recovery byte, primary drive 0 |
| rw_pri1_i | input | 8 | Active/recovery byte, primary drive 1 |
| rw_sec_i | input | 8 | Active/recovery byte, secondary channel |
| rw_cmd_i | input | 8 | Active/recovery byte for command-block accesses |
| rd_stb_o | output | 1 | Read strobe |
| wr_stb_o | output | 1 | Write strobe |
| addr_vld_o | output | 1 | Address valid for the whole cycle |
| done_o | output | 1 | High on the last recovery clock |

## Verification
The critical collision is a new start pulse that lands in the same clock as done_o. That clock must end the old cycle and launch the new one, with no idle cycle between them and no loss of either request. The bench provokes this by timing a second start to the exact clock whose sample shows done_o. It compares this case with one where the second start arrives early, during setup, and is held. In both cases it judges the trace by checking that the first cycle's recovery ends with a single done, that address-valid is still high on the next sample, and that the next setup, active and recovery lengths and strobe kind match the second request.

// File: rtl/pio_tim_pkg.sv
`timescale 1ns/1ps
package pio_tim_pkg;
    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;
    localparam int CODE_W = 2;
    localparam int CNT_W  = $clog2((1 << NIB_W) + 2);

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_ACT   = 2'd2,
        PH_REC   = 2'd3
    } phase_e;

    typedef struct packed {
        logic wr;
        logic chan;
        logic drv;
        logic cmd;
    } req_t;

    typedef struct packed {
        logic [CNT_W-1:0] su;
        logic [CNT_W-1:0] act;
        logic [CNT_W-1:0] rec;
    } lens_t;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] act;
        logic [CNT_W-1:0] rec;
        logic             wr;
        logic             pend;
        req_t             pend_req;
    } seq_t;
endpackage

// File: rtl/pio_tim_sel.sv
`timescale 1ns/1ps
module pio_tim_sel
    import pio_tim_pkg::*;
(
    input  logic              chan_i,
    input  logic              drv_i,
    input  logic              cmd_i,
    input  logic [1:0]        rev_i,
    input  logic [CODE_W-1:0] su_pri0_i,
    input  logic [CODE_W-1:0] su_pri1_i,
    input  logic [CODE_W-1:0] su_sec_i,
    input  logic [BYTE_W-1:0] rw_pri0_i,
    input  logic [BYTE_W-1:0] rw_pri1_i,
    input  logic [BYTE_W-1:0] rw_sec_i,
    input  logic [BYTE_W-1:0] rw_cmd_i,
    output lens_t             lens_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(1 << NIB_W);
    localparam logic [CNT_W-1:0] MIN_ACT  = CNT_W'(2);

    logic [CODE_W-1:0] code_d;
    logic [BYTE_W-1:0] byte_d;
    logic [NIB_W-1:0]  hi_d;
    logic [NIB_W-1:0]  lo_d;

    always_comb begin
        if (chan_i) begin
            code_d = su_sec_i;
            byte_d = rw_sec_i;
        end else if (drv_i) begin
            code_d = su_pri1_i;
            byte_d = rw_pri1_i;
        end else begin
            code_d = su_pri0_i;
            byte_d = rw_pri0_i;
        end
        if (cmd_i) begin
            byte_d = rw_cmd_i;
        end

        case (code_d)
            2'b00:   lens_o.su = CNT_W'(4);
            2'b01:   lens_o.su = CNT_W'(2);
            2'b10:   lens_o.su = CNT_W'(3);
            default: lens_o.su = CNT_W'(5);
        endcase

        hi_d = byte_d[BYTE_W-1 -: NIB_W];
        lo_d = byte_d[NIB_W-1:0];

        lens_o.act = (hi_d == '0) ? FULL_CNT : CNT_W'(hi_d);
        if (lens_o.act < MIN_ACT) begin
            lens_o.act = MIN_ACT;
        end

        lens_o.rec = (lo_d == '0) ? FULL_CNT : CNT_W'(lo_d);
        if (rev_i > 2'd1) begin
            lens_o.rec = lens_o.rec + CNT_W'(1);
        end
    end
endmodule

// File: rtl/pio_tim_seq.sv
`timescale 1ns/1ps
module pio_tim_seq
    import pio_tim_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  start_i,
    input  req_t  in_req_i,
    input  lens_t lens_i,
    output req_t  launch_req_o,
    output logic  rd_stb_o,
    output logic  wr_stb_o,
    output logic  addr_vld_o,
    output logic  done_o
);
    seq_t q, d;
    logic free_d;
    logic go_d;

    assign launch_req_o = q.pend ? q.pend_req : in_req_i;
    assign done_o       = (q.ph == PH_REC) && (q.cnt == '0);
    assign addr_vld_o   = (q.ph != PH_IDLE);
    assign rd_stb_o     = (q.ph == PH_ACT) && !q.wr;
    assign wr_stb_o     = (q.ph == PH_ACT) && q.wr;

    always_comb begin
        d      = q;
        free_d = (q.ph == PH_IDLE) || done_o;
        go_d   = free_d && (q.pend || start_i);

        case (q.ph)
            PH_SETUP: begin
                if (q.cnt == '0) begin
                    d.ph  = PH_ACT;
                    d.cnt = q.act - CNT_W'(1);
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            PH_ACT: begin
                if (q.cnt == '0) begin
                    d.ph  = PH_REC;
                    d.cnt = q.rec - CNT_W'(1);
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            PH_REC: begin
                if (q.cnt == '0) begin
                    d.ph = PH_IDLE;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            default: ;
        endcase

        if (go_d) begin
            d.ph  = PH_SETUP;
            d.cnt = lens_i.su - CNT_W'(1);
            d.act = lens_i.act;
            d.rec = lens_i.rec;
            d.wr  = launch_req_o.wr;
        end

        if (go_d && q.pend) begin
            d.pend     = start_i;
            d.pend_req = in_req_i;
        end else if (!go_d && start_i && !q.pend) begin
            d.pend     = 1'b1;
            d.pend_req = in_req_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assert_one_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rd_stb_o && wr_stb_o));
    assert_strobe_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_stb_o || wr_stb_o) |-> addr_vld_o);
    assert_setup_first_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(addr_vld_o) |-> !(rd_stb_o || wr_stb_o));
    assert_active_min_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rd_stb_o || wr_stb_o) |=> (rd_stb_o || wr_stb_o));
    assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    assert_done_in_rec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (addr_vld_o && !rd_stb_o && !wr_stb_o));
    assert_held_launch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && q.pend) |=> (q.ph == PH_SETUP));
endmodule

// File: rtl/pio_strobe_gen.sv
`timescale 1ns/1ps
module pio_strobe_gen
    import pio_tim_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              wr_i,
    input  logic              chan_i,
    input  logic              drv_i,
    input  logic              cmd_blk_i,
    input  logic [1:0]        rev_i,
    input  logic [CODE_W-1:0] su_pri0_i,
    input  logic [CODE_W-1:0] su_pri1_i,
    input  logic [CODE_W-1:0] su_sec_i,
    input  logic [BYTE_W-1:0] rw_pri0_i,
    input  logic [BYTE_W-1:0] rw_pri1_i,
    input  logic [BYTE_W-1:0] rw_sec_i,
    input  logic [BYTE_W-1:0] rw_cmd_i,
    output logic              rd_stb_o,
    output logic              wr_stb_o,
    output logic              addr_vld_o,
    output logic              done_o
);
    req_t  in_req;
    req_t  launch_req;
    lens_t lens;

    assign in_req = '{wr: wr_i, chan: chan_i, drv: drv_i, cmd: cmd_blk_i};

    pio_tim_sel sel_i (
        .chan_i    (launch_req.chan),
        .drv_i     (launch_req.drv),
        .cmd_i     (launch_req.cmd),
        .rev_i     (rev_i),
        .su_pri0_i (su_pri0_i),
        .su_pri1_i (su_pri1_i),
        .su_sec_i  (su_sec_i),
        .rw_pri0_i (rw_pri0_i),
        .rw_pri1_i (rw_pri1_i),
        .rw_sec_i  (rw_sec_i),
        .rw_cmd_i  (rw_cmd_i),
        .lens_o    (lens)
    );

    pio_tim_seq seq_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start_i),
        .in_req_i     (in_req),
        .lens_i       (lens),
        .launch_req_o (launch_req),
        .rd_stb_o     (rd_stb_o),
        .wr_stb_o     (wr_stb_o),
        .addr_vld_o   (addr_vld_o),
        .done_o       (done_o)
    );
endmodule

// File: tb/pio_strobe_gen_tb.sv
`timescale 1ns/1ps
module pio_strobe_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, wr = 1'b0, chan = 1'b0, drv = 1'b0, cmdb = 1'b0;
    logic [1:0] rev = 2'd1;
    logic [1:0] su0 = '0, su1 = '0, sus = '0;
    logic [7:0] rw0 = '0, rw1 = '0, rws = '0, rwc = '0;
    logic       rd_stb, wr_stb, av, dn;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    bit tr_av [0:127];
    bit tr_rd [0:127];
    bit tr_wr [0:127];
    bit tr_dn [0:127];

    always #10 clk = ~clk;

    pio_strobe_gen dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wr_i(wr), .chan_i(chan),
        .drv_i(drv), .cmd_blk_i(cmdb), .rev_i(rev),
        .su_pri0_i(su0), .su_pri1_i(su1), .su_sec_i(sus),
        .rw_pri0_i(rw0), .rw_pri1_i(rw1), .rw_sec_i(rws), .rw_cmd_i(rwc),
        .rd_stb_o(rd_stb), .wr_stb_o(wr_stb), .addr_vld_o(av), .done_o(dn)
    );

    function automatic int e_su(input int c);
        case (c)
            0: return 4;
            1: return 2;
            2: return 3;
            default: return 5;
        endcase
    endfunction

    function automatic int e_act(input int n);
        if (n == 0) return 16;
        if (n < 2) return 2;
        return n;
    endfunction

    function automatic int e_rec(input int n, input int rv);
        return ((n == 0) ? 16 : n) + ((rv > 1) ? 1 : 0);
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Sample first, then drive; second request fields applied at second_at.
    task automatic capture(input int len, input int second_at,
                           input bit w2, input bit c2, input bit d2, input bit m2);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            tr_av[k] = av; tr_rd[k] = rd_stb; tr_wr[k] = wr_stb; tr_dn[k] = dn;
            if (k == 0) begin
                start = 1'b1;
            end else if (k == second_at) begin
                start = 1'b1; wr = w2; chan = c2; drv = d2; cmdb = m2;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
    endtask

    task automatic verify(input int base, input int len, input int s, input int a,
                          input int r, input bit w, input string tg, output int nxt);
        int k = base;
        int cs = 0, ca = 0, cr = 0, nd = 0;
        bit kind = 0;
        bit stop = 0;
        while (k < len && tr_av[k] && !tr_rd[k] && !tr_wr[k]) begin cs++; k++; end
        if (k < len) kind = tr_wr[k];
        while (k < len && (tr_rd[k] || tr_wr[k])) begin ca++; k++; end
        while (!stop && k < len && tr_av[k] && !tr_rd[k] && !tr_wr[k]) begin
            cr++;
            if (tr_dn[k]) begin nd++; stop = 1; end
            k++;
        end
        chk(cs == s, (tg == "") ? "R1" : tg, "setup clocks", cs, s);
        chk(ca == a, (tg == "") ? "R2" : tg, "active clocks", ca, a);
        chk(kind == w, (tg == "") ? "R2" : tg, "strobe kind", kind, w);
        chk(cr == r, (tg == "") ? "R3" : tg, "recovery clocks", cr, r);
        chk(nd == 1, (tg == "") ? "R4" : tg, "done on last recovery clock", nd, 1);
        nxt = k;
    endtask

    initial begin
        int nx, nx2, s, a, r, len;
        repeat (3) begin
            @(negedge clk);
            chk(!av && !rd_stb && !wr_stb && !dn, "R8", "outputs in reset",
                {av, rd_stb, wr_stb, dn}, 0);
        end
        rst_n = 1'b1;
        repeat (2) begin
            @(negedge clk);
            chk(!av && !rd_stb && !wr_stb && !dn, "R8", "outputs idle after reset",
                {av, rd_stb, wr_stb, dn}, 0);
        end

        // Sweep of every nibble pair on primary drive 0 for two revisions (R1 R2 R3 R4)
        for (int rv = 1; rv <= 2; rv++) begin
            for (int an = 0; an < 16; an++) begin
                for (int rn = 0; rn < 16; rn++) begin
                    int code = (an + rn) % 4;
                    rev = 2'(rv); su0 = 2'(code); rw0 = {4'(an), 4'(rn)};
                    chan = 0; drv = 0; cmdb = 0; wr = 1'((an ^ rn) & 1);
                    s = e_su(code); a = e_act(an); r = e_rec(rn, rv);
                    len = 1 + s + a + r + 3;
                    capture(len, -1, 0, 0, 0, 0);
                    verify(1, len, s, a, r, 1'((an ^ rn) & 1), "", nx);
                    chk(!tr_av[nx], "R4", "address valid drops after done", tr_av[nx], 0);
                end
            end
        end

        // Channel/drive selection (R5)
        rev = 2'd1;
        su0 = 2'b00; rw0 = 8'h23;
        su1 = 2'b01; rw1 = 8'h45;
        sus = 2'b11; rws = 8'h67;
        rwc = 8'h89;
        for (int sel = 0; sel < 4; sel++) begin
            chan = 1'(sel >> 1); drv = 1'(sel & 1); cmdb = 0; wr = 1'(sel & 1);
            if (sel == 0) begin s = 4; a = 2; r = 3; end
            else if (sel == 1) begin s = 2; a = 4; r = 5; end
            else begin s = 5; a = 6; r = 7; end
            len = 1 + s + a + r + 3;
            capture(len, -1, 0, 0, 0, 0);
            verify(1, len, s, a, r, 1'(sel & 1), "R5", nx);
        end

        // Command-block timing (R6)
        for (int rv = 1; rv <= 2; rv++) begin
            rev = 2'(rv); rwc = 8'h00; chan = 0; drv = 1; cmdb = 1; wr = 0;
            len = 1 + 2 + 16 + 16 + rv + 2;
            capture(len, -1, 0, 0, 0, 0);
            verify(1, len, 2, 16, 15 + rv, 0, "R6", nx);
        end
        rev = 2'd1; rwc = 8'h35; chan = 1; drv = 0; cmdb = 1; wr = 1;
        capture(1 + 5 + 3 + 5 + 3, -1, 0, 0, 0, 0);
        verify(1, 17, 5, 3, 5, 1, "R6", nx);

        // Held request: second start during setup, then in the done cycle (R7)
        for (int mode = 0; mode < 2; mode++) begin
            rev = 2'd1; chan = 0; drv = 0; cmdb = 0; wr = 0;
            len = 1 + 9 + 18 + 4;
            capture(len, (mode == 0) ? 3 : 9, 1, 1, 0, 0);
            if (mode == 1) chk(tr_dn[9], "R7", "done seen when second start driven", tr_dn[9], 1);
            verify(1, len, 4, 2, 3, 0, "R7", nx);
            chk(nx == 10, "R7", "first cycle length", nx, 10);
            chk(tr_av[nx], "R7", "no idle gap before held cycle", tr_av[nx], 1);
            verify(nx, len, 5, 6, 7, 1, "R7", nx2);
            chk(!tr_av[nx2], "R7", "idle after held cycle", tr_av[nx2], 0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R4 watchdog: got 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule